// File: doc/BRIEF.md
# Highest-Priority Pending Interrupt Selector

This block looks at the state of a processor's private interrupts and picks the one to present to the processor interface. For each interrupt it receives a pending bit, an enable bit, an active bit, an 8-bit priority and a 2-bit group code. It also receives one enable bit for each group. From these it reports the identifier, priority and group of the best candidate, together with a valid flag. The result is registered, so it follows its inputs with one clock of delay.

A second, independent output answers a separate question: may this processor be chosen as the target of an interrupt that can be delivered to any one of several processors? The group of that interrupt is supplied on a query input. The answer depends on the processor's sleep flag, on the global group enables, and on a set of per-group opt-out bits.

The comparison is a balanced binary tournament. Each node passes on its left entry when the left entry's priority is lower or equal to the right entry's. This rule produces lowest-identifier-wins on ties without any extra comparator.

Top module: `hppi_sel`

## Requirements
- R1: Interrupt i is a candidate exactly when its pending bit is 1, its enable bit is 1, its active bit is 0, and the global enable bit for its group is 1.
- R2: Among candidates, the one with the numerically smallest priority value is reported.
- R3: When several candidates share the smallest priority, the one with the smallest identifier is reported.
- R4: With no candidate, `win_valid_o` is 0, `win_prio_o` is 8'hFF, `win_id_o` is 0 and `win_grp_o` is 0. A lone candidate whose priority is 8'hFF is still reported with `win_valid_o` = 1.
- R5: Group codes are 0 = group 0, 1 = secure group 1, 2 = non-secure group 1, and 3 = reserved. The group enable bit and the opt-out bit for code g sit at bit position g of `grp_en_i` and `grp_dis_i`. An interrupt whose group code is 3 is never a candidate.
- R6: `eligible_o` is 0 whenever `sleep_i` is 1.
- R7: `eligible_o` is 0 when the global enable bit for the queried group is 0, when that group's opt-out bit is 1, or when the query code is 3. Otherwise, with `sleep_i` at 0, it is 1.
- R8: Every output reflects the inputs sampled at the previous rising clock edge. A change on the inputs does not reach the outputs before that edge.
- R9: While the synchronous active-high reset is asserted at a clock edge, the outputs take their idle values: not valid, priority 8'hFF, identifier 0, group 0, and not eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | NUM_IRQ | Per-interrupt pending bits |
| en_i | input | NUM_IRQ | Per-interrupt enable bits |
| act_i | input | NUM_IRQ | Per-interrupt active bits |
| prio_i | input | NUM_IRQ*PRIO_W | Priorities; interrupt i occupies bits [i*PRIO_W +: PRIO_W] |
| grp_i | input | NUM_IRQ*2 | Group codes; interrupt i occupies bits [2i +: 2] |
| grp_en_i | input | 3 | Global group enables, indexed by group code |
| sleep_i | input | 1 | Processor is in low-power state |
| grp_dis_i | input | 3 | Per-group opt-out from one-of-many selection, indexed by group code |
| qgrp_i | input | 2 | Group code of the one-of-many interrupt being routed |
| win_valid_o | output | 1 | A candidate exists |
| win_id_o | output | ID_W | Identifier of the chosen interrupt |
| win_prio_o | output | PRIO_W | Priority of the chosen interrupt, all ones when idle |
| win_grp_o | output | 2 | Group code of the chosen interrupt |
| eligible_o | output | 1 | Processor may receive a one-of-many interrupt of group `qgrp_i` |

## Verification
Fully random state vectors exercise the candidate rule and the minimum search together. Priorities drawn from only two values force many ties, which separates a lowest-identifier tie-break from a highest-identifier or last-seen one. All-inactive vectors, disabled groups and reserved group codes check the idle encoding. A single candidate at the top identifier with priority 8'hFF shows that validity is tracked separately from the priority value. An exhaustive sweep of sleep, enables, opt-outs and query codes covers the eligibility output, and checks made just before each edge confirm that the outputs hold their values until then.

// File: rtl/hppi_pkg.sv
package hppi_pkg;

  localparam int GRP_W = 2;

  typedef enum logic [GRP_W-1:0] {
    GRP_0   = 2'd0,
    GRP_1S  = 2'd1,
    GRP_1NS = 2'd2,
    GRP_RSV = 2'd3
  } grp_e;

  // Selects the per-group bit for a group code; reserved code yields 0.
  function automatic logic grp_bit(input logic [GRP_W-1:0] g, input logic [2:0] bits);
    case (g)
      GRP_0:   grp_bit = bits[0];
      GRP_1S:  grp_bit = bits[1];
      GRP_1NS: grp_bit = bits[2];
      default: grp_bit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/hppi_cand.sv
module hppi_cand
  import hppi_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic [NUM_IRQ-1:0]       pend_i,
  input  logic [NUM_IRQ-1:0]       en_i,
  input  logic [NUM_IRQ-1:0]       act_i,
  input  logic [NUM_IRQ*GRP_W-1:0] grp_i,
  input  logic [2:0]               grp_en_i,
  output logic [NUM_IRQ-1:0]       cand_o
);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    logic [GRP_W-1:0] g;
    assign g         = grp_i[i*GRP_W +: GRP_W];
    assign cand_o[i] = pend_i[i] & en_i[i] & ~act_i[i] & grp_bit(g, grp_en_i);
  end

endmodule

// File: rtl/hppi_tree.sv
module hppi_tree
  import hppi_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 8,
  localparam int ID_W   = $clog2(NUM_IRQ),
  localparam int NODES  = 2*NUM_IRQ - 1
) (
  input  logic [NUM_IRQ-1:0]        cand_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
  input  logic [NUM_IRQ*GRP_W-1:0]  grp_i,
  output logic                      valid_o,
  output logic [ID_W-1:0]           id_o,
  output logic [PRIO_W-1:0]         prio_o,
  output logic [GRP_W-1:0]          grp_o
);

  // Heap layout: node k has children 2k+1 (lower IDs) and 2k+2.
  logic              v [NODES];
  logic [PRIO_W-1:0] p [NODES];
  logic [ID_W-1:0]   d [NODES];
  logic [GRP_W-1:0]  g [NODES];

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_leaf
    assign v[NUM_IRQ-1+i] = cand_i[i];
    assign p[NUM_IRQ-1+i] = cand_i[i] ? prio_i[i*PRIO_W +: PRIO_W] : {PRIO_W{1'b1}};
    assign d[NUM_IRQ-1+i] = cand_i[i] ? ID_W'(i) : '0;
    assign g[NUM_IRQ-1+i] = cand_i[i] ? grp_i[i*GRP_W +: GRP_W] : GRP_0;
  end

  for (genvar k = 0; k < NUM_IRQ-1; k++) begin : g_node
    logic take_l;
    // Left side holds lower IDs: it keeps the slot on equal priority.
    assign take_l = v[2*k+1] && (!v[2*k+2] || (p[2*k+1] <= p[2*k+2]));
    assign v[k]   = v[2*k+1] | v[2*k+2];
    assign p[k]   = take_l ? p[2*k+1] : p[2*k+2];
    assign d[k]   = take_l ? d[2*k+1] : d[2*k+2];
    assign g[k]   = take_l ? g[2*k+1] : g[2*k+2];
  end

  assign valid_o = v[0];
  assign prio_o  = p[0];
  assign id_o    = d[0];
  assign grp_o   = g[0];

endmodule

// File: rtl/hppi_elig.sv
module hppi_elig
  import hppi_pkg::*;
(
  input  logic             sleep_i,
  input  logic [2:0]       grp_en_i,
  input  logic [2:0]       grp_dis_i,
  input  logic [GRP_W-1:0] qgrp_i,
  output logic             ok_o
);

  assign ok_o = ~sleep_i & grp_bit(qgrp_i, grp_en_i) & ~grp_bit(qgrp_i, grp_dis_i);

endmodule

// File: rtl/hppi_sel.sv
module hppi_sel
  import hppi_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 8,
  localparam int ID_W   = $clog2(NUM_IRQ)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_IRQ-1:0]        pend_i,
  input  logic [NUM_IRQ-1:0]        en_i,
  input  logic [NUM_IRQ-1:0]        act_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
  input  logic [NUM_IRQ*2-1:0]      grp_i,
  input  logic [2:0]                grp_en_i,
  input  logic                      sleep_i,
  input  logic [2:0]                grp_dis_i,
  input  logic [1:0]                qgrp_i,
  output logic                      win_valid_o,
  output logic [ID_W-1:0]           win_id_o,
  output logic [PRIO_W-1:0]         win_prio_o,
  output logic [1:0]                win_grp_o,
  output logic                      eligible_o
);

  logic [NUM_IRQ-1:0] cand;
  logic               t_valid;
  logic [ID_W-1:0]    t_id;
  logic [PRIO_W-1:0]  t_prio;
  logic [GRP_W-1:0]   t_grp;
  logic               elig_c;

  hppi_cand #(.NUM_IRQ(NUM_IRQ)) u_cand (
    .pend_i   (pend_i),
    .en_i     (en_i),
    .act_i    (act_i),
    .grp_i    (grp_i),
    .grp_en_i (grp_en_i),
    .cand_o   (cand)
  );

  hppi_tree #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_tree (
    .cand_i  (cand),
    .prio_i  (prio_i),
    .grp_i   (grp_i),
    .valid_o (t_valid),
    .id_o    (t_id),
    .prio_o  (t_prio),
    .grp_o   (t_grp)
  );

  hppi_elig u_elig (
    .sleep_i   (sleep_i),
    .grp_en_i  (grp_en_i),
    .grp_dis_i (grp_dis_i),
    .qgrp_i    (qgrp_i),
    .ok_o      (elig_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      win_valid_o <= 1'b0;
      win_id_o    <= '0;
      win_prio_o  <= {PRIO_W{1'b1}};
      win_grp_o   <= GRP_0;
      eligible_o  <= 1'b0;
    end else begin
      win_valid_o <= t_valid;
      win_id_o    <= t_id;
      win_prio_o  <= t_prio;
      win_grp_o   <= t_grp;
      eligible_o  <= elig_c;
    end
  end

  // History of the candidate mask, kept for the checks below only.
  logic [NUM_IRQ-1:0] cand_prev;
  always_ff @(posedge clk) begin
    if (rst) cand_prev <= '0;
    else     cand_prev <= cand;
  end

  p_win_is_cand_r1: assert property (@(posedge clk) disable iff (rst)
    win_valid_o |-> cand_prev[win_id_o]);

  p_valid_any_r1: assert property (@(posedge clk) disable iff (rst)
    win_valid_o == (|cand_prev));

  p_idle_ff_r4: assert property (@(posedge clk) disable iff (rst)
    !win_valid_o |-> (win_prio_o == {PRIO_W{1'b1}} && win_id_o == '0));

  p_no_rsv_grp_r5: assert property (@(posedge clk) disable iff (rst)
    win_valid_o |-> win_grp_o != GRP_RSV);

  p_sleep_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    $past(sleep_i) |-> !eligible_o);

  p_rsv_query_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(qgrp_i) == GRP_RSV) |-> !eligible_o);

endmodule

// File: tb/hppi_sel_tb.sv
module hppi_sel_tb_top;
  localparam int N  = 32;
  localparam int PW = 8;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [N-1:0]    pend, en, act;
  logic [N*PW-1:0] prio;
  logic [N*2-1:0]  grp;
  logic [2:0]      gen, dis;
  logic            sleep;
  logic [1:0]      qg;
  logic            o_valid, o_elig;
  logic [IW-1:0]   o_id;
  logic [PW-1:0]   o_prio;
  logic [1:0]      o_grp;

  hppi_sel #(.NUM_IRQ(N), .PRIO_W(PW)) dut_i (
    .clk(clk), .rst(rst), .pend_i(pend), .en_i(en), .act_i(act),
    .prio_i(prio), .grp_i(grp), .grp_en_i(gen), .sleep_i(sleep),
    .grp_dis_i(dis), .qgrp_i(qg), .win_valid_o(o_valid), .win_id_o(o_id),
    .win_prio_o(o_prio), .win_grp_o(o_grp), .eligible_o(o_elig)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  // Expected values for the outputs currently on the pins.
  int e_valid = 0, e_id = 0, e_prio = 255, e_grp = 0, e_elig = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic chk(input string what, input string req, input int act_v, input int exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act_v, exp_v, $time);
    end
  endtask

  task automatic check_all(input string req);
    chk("valid", req, int'(o_valid), e_valid);
    chk("id", req, int'(o_id), e_id);
    chk("prio", req, int'(o_prio), e_prio);
    chk("grp", req, int'(o_grp), e_grp);
    chk("eligible", "R6 R7", int'(o_elig), e_elig);
  endtask

  function automatic int gbit(input int g, input logic [2:0] b);
    return (g < 3) ? int'(b[g]) : 0;
  endfunction

  // Behavioural scan in ascending ID order; strict less-than keeps the first.
  task automatic model();
    int bp;
    e_valid = 0; e_id = 0; e_prio = 255; e_grp = 0;
    bp = 256;
    for (int i = 0; i < N; i++) begin
      int g, p;
      g = int'(grp[2*i +: 2]);
      p = int'(prio[PW*i +: PW]);
      if (pend[i] && en[i] && !act[i] && gbit(g, gen) == 1 && p < bp) begin
        bp = p; e_valid = 1; e_id = i; e_prio = p; e_grp = g;
      end
    end
    e_elig = (!sleep && gbit(int'(qg), gen) == 1 && gbit(int'(qg), dis) == 0) ? 1 : 0;
  endtask

  // Called at a falling edge after new inputs are applied.
  task automatic step(input string req);
    #1;
    check_all("R8");            // old values must still be on the pins
    if (rst) begin
      e_valid = 0; e_id = 0; e_prio = 255; e_grp = 0; e_elig = 0;
    end else model();
    @(posedge clk);
    @(negedge clk);
    check_all(req);
  endtask

  task automatic randomize_state(input int prio_mode);
    pend = {$urandom, $urandom} ; en = $urandom | $urandom; act = $urandom & $urandom;
    for (int i = 0; i < N; i++) begin
      case (prio_mode)
        0: prio[PW*i +: PW] = PW'($urandom);
        1: prio[PW*i +: PW] = ($urandom_range(0, 1) == 1) ? 8'h10 : 8'h20;
        default: prio[PW*i +: PW] = 8'h40;
      endcase
      grp[2*i +: 2] = 2'($urandom_range(0, 2));
    end
    gen = 3'($urandom); dis = 3'($urandom); sleep = 1'($urandom); qg = 2'($urandom);
  endtask

  initial begin
    pend = '0; en = '0; act = '0; prio = '0; grp = '0;
    gen = '0; dis = '0; sleep = 1'b0; qg = '0;
    @(negedge clk);
    // R9: reset overrides any active input state
    randomize_state(0); gen = 3'b111; en = '1; act = '0; pend = '1; sleep = 1'b0; dis = '0;
    step("R9");
    step("R9");
    rst = 1'b0;
    step("R1");

    // R4: no candidate in several ways
    pend = '0; step("R4");
    pend = '1; en = '1; act = '1; step("R4");
    act = '0; gen = 3'b000; step("R4");
    // R4: lone candidate at top ID with priority FF is still valid
    gen = 3'b111; pend = '0; pend[N-1] = 1'b1; prio[PW*(N-1) +: PW] = 8'hFF;
    grp[2*(N-1) +: 2] = 2'd2; step("R4");

    // R2: random states
    for (int k = 0; k < 300; k++) begin randomize_state(0); step("R2"); end
    // R1: enable, active and group filters with full pending
    for (int k = 0; k < 50; k++) begin randomize_state(0); pend = '1; step("R1"); end

    // R3: ties
    for (int k = 0; k < 150; k++) begin randomize_state(1); step("R3"); end
    randomize_state(2); pend = '1; en = '1; act = '0; gen = 3'b111; step("R3");
    act[0] = 1'b1; act[1] = 1'b1; step("R3");

    // R5: reserved group code is never a candidate
    pend = '1; en = '1; act = '0; gen = 3'b111;
    for (int i = 0; i < N; i++) grp[2*i +: 2] = 2'd3;
    step("R5");
    grp[2*7 +: 2] = 2'd1; step("R5");
    for (int k = 0; k < 40; k++) begin
      randomize_state(0);
      for (int i = 0; i < N; i++) grp[2*i +: 2] = 2'($urandom);
      step("R5");
    end

    // R6 R7: exhaustive eligibility sweep
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++)
          for (int q = 0; q < 4; q++) begin
            sleep = 1'(s); gen = 3'(a); dis = 3'(b); qg = 2'(q);
            step(s == 1 ? "R6" : "R7");
          end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule